// File: doc/BRIEF.md
# Bus Handover Controller for an External Requester

This block decides who drives a shared external address/data bus: the chip's own bus master or an outside requester such as a DMA engine. The outside requester pulls an active-low request line. The controller synchronizes that line to the system clock and waits until the internal master reaches a bus-cycle boundary. A boundary comes only after the cycle's base states and any wait-stretched final state have run out. The controller then turns off every external pad driver group: multiplexed address/data, upper address, read/write strobes, the row strobe and each chip-select/column strobe. One clock later it pulls the active-low acknowledge low.

While the bus is handed over, a hold signal stalls the internal master, and an on-chip access enable stays low. This keeps the outside requester away from internal memory and registers. When the request line goes high again, the acknowledge rises first. The drivers come back one clock later, and in that same clock the internal master is released.

The internal master reports each new bus cycle with a one-clock start pulse. The controller counts the cycle's states itself and stretches the final state for as long as the wait input is low.

Top module: `bus_handover_ctrl`

## Requirements
- R1: During and right after reset, `ack_n` is 1, every output enable is 1, `hold` is 0 and `onchip_en` is 1.
- R2: The request passes through SYNC_STAGES (default 2) flip-flops. With no bus cycle in progress, a low `breq_n` first sampled at clock edge k turns the output enables off after edge k+2 and drives `ack_n` to 0 after edge k+3.
- R3: All output enables fall exactly one clock before `ack_n` falls, and rise exactly one clock after `ack_n` rises. All enable groups always carry the same value.
- R4: A `cyc_start` accepted at edge t makes the bus busy for BASE_STATES (default 3) clocks when `wait_n` stays high. The enables turn off no earlier than edge t+BASE_STATES+1, even with the request already pending.
- R5: Each edge at which the final state of a cycle samples `wait_n` low adds one clock to that cycle. The handover begins only on the clock after the stretched cycle ends.
- R6: `hold` is 1 whenever the controller is not in the owned state, and also while a synchronized request is pending with no cycle in progress. A `cyc_start` sampled while `hold` is 1 or while a cycle is in progress is ignored and adds no bus-busy time.
- R7: While `ack_n` is 0, `onchip_en` is 0, `hold` is 1 and every output enable is 0.
- R8: A high `breq_n` first sampled at edge m, while granted, drives `ack_n` to 1 after edge m+2. It turns the enables back on and drops `hold` after edge m+3.
- R9: Once asserted, `ack_n` stays 0 for as long as the synchronized request stays low. It falls only once per handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| breq_n | input | 1 | External bus request, active low, asynchronous |
| wait_n | input | 1 | Wait input, active low, stretches the final state of a cycle |
| cyc_start | input | 1 | Internal master starts a bus cycle (one-clock pulse) |
| hold | output | 1 | Stalls the internal master |
| ack_n | output | 1 | Bus acknowledge, active low |
| onchip_en | output | 1 | Enables on-chip memory and I/O access; low while the bus is handed over |
| oe_ad | output | 1 | Driver enable for the multiplexed address/data lines |
| oe_addr | output | 1 | Driver enable for the upper address lines |
| oe_strb | output | 1 | Driver enable for the read, write, high-byte write and read/write strobes |
| oe_ras | output | 1 | Driver enable for the row address strobe |
| oe_cs | output | NUM_CS | Driver enables for each chip-select/column strobe |

## Verification
The bench sweeps the arrival of the request over nine offsets around a bus-cycle start, from several clocks before it to well after it. It crosses each offset with zero to three wait-stretched clocks. Early offsets show that a pending request blocks a new cycle, and that a blocked start adds no busy time. Middle offsets show that the grant waits for the base states and any wait states, and late offsets show the pure synchronizer latency. Each case then withdraws the request, which checks the release order and latency and the stall and on-chip blocking throughout the handover.

// File: rtl/bus_handover_pkg.sv
// Shared types for the bus handover controller.
// Assumes: a single clock domain after the request synchronizer.
package bus_handover_pkg;

    // Handover sequence; the order of states is the order of events on the pads.
    typedef enum logic [1:0] {
        HS_OWN    = 2'd0,   // internal master owns the bus, drivers on
        HS_FLOAT  = 2'd1,   // drivers off, acknowledge still high
        HS_GRANT  = 2'd2,   // acknowledge low, external requester owns the bus
        HS_RETURN = 2'd3    // acknowledge high again, drivers still off
    } hs_state_t;

endpackage

// File: rtl/req_synchronizer.sv
// Brings the asynchronous active-low request into the clock domain.
// Output is active high. Assumes STAGES >= 1; reset value means "no request".
module req_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_req_n,
    output logic req_level
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop sample of the request line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= async_req_n;
            end
        end else begin : g_multi
            // Shift the request line through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_req_n};
            end
        end
    endgenerate

    assign req_level = ~chain[STAGES-1];

endmodule

// File: rtl/cycle_tracker.sv
// Tracks whether the internal master is inside a bus cycle.
// A cycle lasts BASE_STATES clocks; its final state repeats while wait_n is low.
// Assumes start pulses are only meaningful when the tracker is idle.
module cycle_tracker #(
    parameter int BASE_STATES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wait_n,
    output logic busy
);

    localparam int CW = $clog2(BASE_STATES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BASE_STATES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] remain;
    logic          take;

    assign busy = (remain != '0);
    assign take = start && !busy;

    // Count down the states of the current cycle; hold on the last while waited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (take) begin
            remain <= LOAD;
        end else if (remain > ONE) begin
            remain <= remain - ONE;
        end else if (remain == ONE && wait_n) begin
            remain <= '0;
        end
    end

endmodule

// File: rtl/handover_fsm.sv
// Sequences the bus handover: drivers off, acknowledge, release, drivers on.
// Assumes req is already synchronized and busy marks a cycle in progress.
module handover_fsm
    import bus_handover_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      busy,
    output hs_state_t state,
    output logic      stall
);

    hs_state_t nxt;

    // Next-state choice; a grant only starts on a cycle boundary.
    always_comb begin
        nxt = state;
        unique case (state)
            HS_OWN:    if (req && !busy) nxt = HS_FLOAT;
            HS_FLOAT:  nxt = HS_GRANT;
            HS_GRANT:  if (!req) nxt = HS_RETURN;
            HS_RETURN: nxt = HS_OWN;
            default:   nxt = HS_OWN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_OWN;
        else        state <= nxt;
    end

    // Stall the master during handover and when a grant is about to start.
    assign stall = (state != HS_OWN) || (req && !busy);

endmodule

// File: rtl/pad_enable_bank.sv
// Fans the single drive permission out to every external driver group.
// Assumes one shared permission for all groups; NUM_CS chip-select groups.
module pad_enable_bank #(
    parameter int NUM_CS = 3
) (
    input  logic              drive,
    output logic              en_ad,
    output logic              en_addr,
    output logic              en_strb,
    output logic              en_ras,
    output logic [NUM_CS-1:0] en_cs
);

    assign en_ad   = drive;
    assign en_addr = drive;
    assign en_strb = drive;
    assign en_ras  = drive;

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            assign en_cs[i] = drive;
        end
    endgenerate

endmodule

// File: rtl/bus_handover_ctrl.sv
// Top of the external bus handover controller.
// Grants the shared bus to an external requester on a cycle boundary, with the
// drivers off before acknowledge and back on after it. Assumes the internal
// master starts cycles only with cyc_start and obeys hold.
module bus_handover_ctrl
    import bus_handover_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_STATES = 3,
    parameter int NUM_CS      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              breq_n,
    input  logic              wait_n,
    input  logic              cyc_start,
    output logic              hold,
    output logic              ack_n,
    output logic              onchip_en,
    output logic              oe_ad,
    output logic              oe_addr,
    output logic              oe_strb,
    output logic              oe_ras,
    output logic [NUM_CS-1:0] oe_cs
);

    logic      req_s;
    logic      cyc_busy;
    logic      stall;
    hs_state_t hs_state;

    req_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_req_n (breq_n),
        .req_level   (req_s)
    );

    cycle_tracker #(.BASE_STATES(BASE_STATES)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start && !stall),
        .wait_n (wait_n),
        .busy   (cyc_busy)
    );

    handover_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_s),
        .busy  (cyc_busy),
        .state (hs_state),
        .stall (stall)
    );

    pad_enable_bank #(.NUM_CS(NUM_CS)) u_pads (
        .drive   (hs_state == HS_OWN),
        .en_ad   (oe_ad),
        .en_addr (oe_addr),
        .en_strb (oe_strb),
        .en_ras  (oe_ras),
        .en_cs   (oe_cs)
    );

    assign ack_n     = (hs_state != HS_GRANT);
    assign onchip_en = (hs_state == HS_OWN);
    assign hold      = stall;

endmodule

// File: rtl/bus_handover_ctrl_chk.sv
// Checker for the bus handover controller; bound into every instance.
module bus_handover_ctrl_chk #(
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_s,
    input logic              busy,
    input logic              hold,
    input logic              ack_n,
    input logic              onchip_en,
    input logic              oe_ad,
    input logic              oe_addr,
    input logic              oe_strb,
    input logic              oe_ras,
    input logic [NUM_CS-1:0] oe_cs
);

    // R3: drivers are already off in the clock before acknowledge falls.
    p_off_before_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> !oe_ad && !$past(oe_ad));

    // R8: drivers come back only after acknowledge has been high a clock.
    p_on_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_ad) |-> ack_n && $past(ack_n));

    // R7: while granted, on-chip access is blocked and the master stalled.
    p_blocked_when_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !onchip_en && hold && !oe_strb && (oe_cs == '0));

    // R4: the drivers never switch off in the middle of a bus cycle.
    p_boundary_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_addr) |-> !$past(busy));

    // R9: acknowledge stays low while the request stays asserted.
    p_ack_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && req_s) |=> !ack_n);

    // R6: any driver-off state keeps the internal master stalled.
    p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ras |-> hold);

endmodule

bind bus_handover_ctrl bus_handover_ctrl_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .busy      (cyc_busy),
    .hold      (hold),
    .ack_n     (ack_n),
    .onchip_en (onchip_en),
    .oe_ad     (oe_ad),
    .oe_addr   (oe_addr),
    .oe_strb   (oe_strb),
    .oe_ras    (oe_ras),
    .oe_cs     (oe_cs)
);

// File: tb/bus_handover_ctrl_bench.sv
`timescale 1ns/1ps
module bus_handover_ctrl_bench;

    localparam int SYNC  = 2;
    localparam int BASE  = 3;
    localparam int NCS   = 3;
    localparam int REL   = 20;   // release edge offset from cycle start

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic breq_n = 1'b1;
    logic wait_n = 1'b1;
    logic cyc_start = 1'b0;
    logic hold, ack_n, onchip_en, oe_ad, oe_addr, oe_strb, oe_ras;
    logic [NCS-1:0] oe_cs;

    int edge_no = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) edge_no <= edge_no + 1;

    bus_handover_ctrl #(.SYNC_STAGES(SYNC), .BASE_STATES(BASE), .NUM_CS(NCS)) u_bus_handover_ctrl (
        .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .wait_n(wait_n),
        .cyc_start(cyc_start), .hold(hold), .ack_n(ack_n), .onchip_en(onchip_en),
        .oe_ad(oe_ad), .oe_addr(oe_addr), .oe_strb(oe_strb), .oe_ras(oe_ras),
        .oe_cs(oe_cs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One handover: cycle start at edge t, request first sampled at t+d,
    // w wait clocks in the final state, release sampled at t+REL.
    task automatic run_case(input int d, input int w);
        int t, k, rel, exp_float, nxt;
        int oe_fall, ack_fall, ack_rise, oe_rise, hold_fall, n_ack_falls;
        bit prev_oe, prev_ack, prev_hold, bad_grant, bad_group;
        string tag;
        @(negedge clk);
        t = edge_no + 5;
        k = t + d;
        rel = t + REL;
        oe_fall = -1; ack_fall = -1; ack_rise = -1; oe_rise = -1; hold_fall = -1;
        n_ack_falls = 0; bad_grant = 0; bad_group = 0;
        prev_oe = oe_ad; prev_ack = ack_n; prev_hold = hold;
        for (int i = 0; i < REL + 10; i++) begin
            // observe state after edge_no
            if (prev_oe && !oe_ad) oe_fall = edge_no;
            if (!prev_oe && oe_ad) oe_rise = edge_no;
            if (prev_ack && !ack_n) begin ack_fall = edge_no; n_ack_falls++; end
            if (!prev_ack && ack_n) ack_rise = edge_no;
            if (prev_hold && !hold) hold_fall = edge_no;
            if (!ack_n && (onchip_en || !hold || oe_ad || oe_strb || oe_ras || (oe_cs != '0)))
                bad_grant = 1;
            if ((oe_addr != oe_ad) || (oe_strb != oe_ad) || (oe_ras != oe_ad) ||
                (oe_cs != {NCS{oe_ad}}))
                bad_group = 1;
            prev_oe = oe_ad; prev_ack = ack_n; prev_hold = hold;
            // drive inputs for the next edge
            nxt = edge_no + 1;
            cyc_start = (nxt == t);
            wait_n    = !((nxt >= t + BASE) && (nxt < t + BASE + w));
            breq_n    = !((nxt >= k) && (nxt < rel));
            @(negedge clk);
        end
        cyc_start = 0; wait_n = 1; breq_n = 1;
        // expected float edge from the requirements
        if (d <= -2) begin
            exp_float = k + SYNC;                               // start blocked by hold
            tag = "R6";
        end else begin
            exp_float = (k + SYNC > t + BASE + w + 1) ? k + SYNC : t + BASE + w + 1;
            tag = (k + SYNC > t + BASE + w + 1) ? "R2" : ((w > 0) ? "R5" : "R4");
        end
        chk($sformatf("%s drivers-off edge d=%0d w=%0d", tag, d, w), oe_fall - t, exp_float - t);
        chk($sformatf("R3 ack falls one clock after drivers off d=%0d w=%0d", d, w), ack_fall, oe_fall + 1);
        chk($sformatf("R8 ack rise edge d=%0d w=%0d", d, w), ack_rise - t, rel + 2 - t);
        chk($sformatf("R3 drivers on one clock after ack rise d=%0d w=%0d", d, w), oe_rise, ack_rise + 1);
        chk($sformatf("R6 hold release edge d=%0d w=%0d", d, w), hold_fall - t, rel + 3 - t);
        chk($sformatf("R7 grant blocks on-chip and drivers d=%0d w=%0d", d, w), int'(bad_grant), 0);
        chk($sformatf("R3 driver groups agree d=%0d w=%0d", d, w), int'(bad_group), 0);
        chk($sformatf("R9 single ack assertion d=%0d w=%0d", d, w), n_ack_falls, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1 ack_n in reset", int'(ack_n), 1);
        chk("R1 drivers in reset", int'({oe_ad, oe_addr, oe_strb, oe_ras, oe_cs}), (1 << (4 + NCS)) - 1);
        chk("R1 hold in reset", int'(hold), 0);
        chk("R1 onchip_en in reset", int'(onchip_en), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ack_n after reset", int'(ack_n), 1);
        chk("R1 hold after reset", int'(hold), 0);
        for (int d = -3; d <= 5; d++)
            for (int w = 0; w <= 3; w++)
                run_case(d, w);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule